// File: doc/BRIEF.md
# Dual-Channel Bus-Master Disk Controller Register Block

This block holds the host-visible registers of a two-channel bus-master disk controller and merges the interrupt requests of both channels onto a single level-sensitive line. The host reaches the registers through a byte-addressed window of eight locations per channel. Address bit 3 picks the channel, and bits 2:0 pick the location. Each window holds a command byte, a mode byte that both channels share, a status byte, a timing byte owned by that channel, and a 32-bit pointer to the descriptor table.

The drive-side logic of each channel gives the block three signals. The first is a single-cycle request pulse. The second is a flag that suppresses interrupts. The third is a strobe that fires when the task-file status is read. The shared mode byte records which channels have an interrupt pending and which channels the host has blocked. The output line is high while at least one channel is pending and not blocked.

A parameter selects between two variants. The extended variant has the mode byte and the timing bytes. The plain variant returns all ones at those locations and ignores writes to them.

Top module: `ide_busmaster_regs`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and `intrq` is low.
- R2: `addr[3]` selects the channel window. `addr[2:0]` maps the window as follows: 0 is the command byte, 1 is the shared mode byte, 2 is the status byte, 3 is the timing byte, and 4 to 7 are the descriptor pointer. Read data appears on `rd_data` in the cycle after `rd_en`. Byte registers are zero-extended. `rd_data` holds its value while no read is made.
- R3: The command byte keeps bit 0 (start) and bit 3 (direction, a set bit means the engine writes memory) exactly as written. All of its other bits read as zero.
- R4: A status write stores bits 5 and 6 as written. Bit 2 (interrupt) is cleared where a 1 is written and kept where a 0 is written. Bits 0, 1, 3, 4 and 7 always read zero.
- R5: In the mode byte, bit 2 is channel 0 pending, bit 3 is channel 1 pending, bit 4 is channel 0 blocked and bit 5 is channel 1 blocked. A host write to this byte through either window changes only bits 4 and 5 and leaves the pending bits unchanged. Bits 0, 1, 6 and 7 read zero. Both windows return the same byte.
- R6: From the clock edge after any change to the pending or blocked bits, `intrq` equals (pending0 AND NOT blocked0) OR (pending1 AND NOT blocked1).
- R7: A pulse on `irq_req[c]` while `irq_dis[c]` is low sets status bit 2 of channel c and pending bit (2+c). While `irq_dis[c]` is high, the pulse changes nothing. If a request and a host write-1-to-clear of status bit 2 arrive in the same cycle, the bit stays set.
- R8: A pulse on `sts_rd[c]` clears pending bit (2+c) only. It leaves the status byte unchanged. If a request for channel c arrives in the same cycle, the request wins and the bit stays set.
- R9: Each channel's timing byte is fully readable and writable at offset 3 of its own window and is independent of the other channel's.
- R10: A write to any of offsets 4 to 7 loads the channel's whole 32-bit descriptor pointer from `wr_data`. Bits 1:0 of the pointer always read zero.
- R11: With `EXTENDED` = 0, offsets 1 and 3 read 0x000000FF in both windows, and writes to those offsets are ignored. All other locations behave as in the extended variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Bit 3 selects the channel, bits 2:0 select the location |
| wr_data | input | 32 | Write data; byte registers use bits 7:0 |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_req | input | 2 | Per-channel single-cycle interrupt request pulse |
| irq_dis | input | 2 | Per-channel drive-side interrupt disable |
| sts_rd | input | 2 | Per-channel strobe for a task-file status read |
| intrq | output | 1 | Combined level-sensitive interrupt |

## Verification
Register reads are due one edge after the read strobe. The bench therefore records each strobe at the edge and compares the data at the following falling edge, popping the expected value that the driver queued when it issued the read. Host writes, request pulses and status-read strobes all take effect at the edge that samples them, and `intrq` reflects that edge's result. The bench checks `intrq` at the falling edge that ends each stimulus, and it checks the state that a write or strobe could have touched with a read made before the next stimulus. A second instance built as the plain variant sees the same traffic, and its read data is compared against the all-ones rule at the extension locations.

// File: rtl/ide_busmaster_regs.sv
module ide_busmaster_regs #(
  parameter bit EXTENDED = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [1:0]  irq_req,
  input  logic [1:0]  irq_dis,
  input  logic [1:0]  sts_rd,
  output logic        intrq
);
  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_MODE = 3'd1;
  localparam logic [2:0] OFF_STS  = 3'd2;
  localparam logic [2:0] OFF_TIM  = 3'd3;
  localparam logic [7:0] CMD_MASK = 8'h09;

  logic       ch;
  logic [2:0] off;
  assign ch  = addr[3];
  assign off = addr[2:0];

  logic [7:0]  cmd  [2];
  logic [1:0]  cap  [2];
  logic [29:0] dtp  [2];
  logic [1:0]  ibit, pend, blk;
  logic [1:0]  set_c, pend_n, ibit_n, blk_n;
  logic [7:0]  mode_rd, tim_rd0, tim_rd1;
  logic [31:0] rv;

  logic wr_cmd, wr_mode, wr_sts, wr_tim, wr_dtp;
  assign wr_cmd  = wr_en && off == OFF_CMD;
  assign wr_mode = wr_en && off == OFF_MODE;
  assign wr_sts  = wr_en && off == OFF_STS;
  assign wr_tim  = wr_en && off == OFF_TIM;
  assign wr_dtp  = wr_en && off[2];

  assign set_c  = irq_req & ~irq_dis;
  assign pend_n = set_c | (pend & ~sts_rd);

  for (genvar c = 0; c < 2; c++) begin : g_ibit
    assign ibit_n[c] = set_c[c] |
                       (ibit[c] & ~(wr_sts && ch == c[0] && wr_data[2]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd[0] <= '0; cmd[1] <= '0;
      cap[0] <= '0; cap[1] <= '0;
      dtp[0] <= '0; dtp[1] <= '0;
      ibit   <= '0;
      pend   <= '0;
      intrq  <= 1'b0;
    end else begin
      if (wr_cmd) cmd[ch] <= wr_data[7:0] & CMD_MASK;
      if (wr_sts) cap[ch] <= wr_data[6:5];
      if (wr_dtp) dtp[ch] <= wr_data[31:2];
      ibit  <= ibit_n;
      pend  <= pend_n;
      intrq <= |(pend_n & ~blk_n);
    end
  end

  if (EXTENDED) begin : g_ext
    logic [7:0] tim [2];
    assign blk_n   = wr_mode ? wr_data[5:4] : blk;
    assign mode_rd = {2'b00, blk, pend, 2'b00};
    assign tim_rd0 = tim[0];
    assign tim_rd1 = tim[1];
    always_ff @(posedge clk) begin
      if (rst) begin
        blk    <= '0;
        tim[0] <= '0;
        tim[1] <= '0;
      end else begin
        blk <= blk_n;
        if (wr_tim) tim[ch] <= wr_data[7:0];
      end
    end
  end else begin : g_plain
    assign blk     = 2'b00;
    assign blk_n   = 2'b00;
    assign mode_rd = 8'hFF;
    assign tim_rd0 = 8'hFF;
    assign tim_rd1 = 8'hFF;

    p_plain_ff_r11: assert property (@(posedge clk) disable iff (rst)
      rd_en && !addr[2] && addr[0] |=> rd_data == 32'h0000_00FF);
  end

  always_comb begin
    case (off)
      OFF_CMD:  rv = {24'h0, cmd[ch]};
      OFF_MODE: rv = {24'h0, mode_rd};
      OFF_STS:  rv = {24'h0, 1'b0, cap[ch], 2'b00, ibit[ch], 2'b00};
      OFF_TIM:  rv = {24'h0, ch ? tim_rd1 : tim_rd0};
      default:  rv = {dtp[ch], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rv;
  end

  p_irq_or_r6: assert property (@(posedge clk) disable iff (rst)
    intrq == |(pend & ~blk));

  p_mode_wr_keeps_pend_r5: assert property (@(posedge clk) disable iff (rst)
    wr_mode && set_c == 2'b00 && sts_rd == 2'b00 |=> $stable(pend));

  p_addr_align_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr[2] |=> rd_data[1:0] == 2'b00);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    p_req_sets_r7: assert property (@(posedge clk) disable iff (rst)
      irq_req[c] && !irq_dis[c] |=> pend[c] && ibit[c]);

    p_strobe_clears_r8: assert property (@(posedge clk) disable iff (rst)
      sts_rd[c] && !set_c[c] |=> !pend[c]);
  end
endmodule

// File: tb/tb_ide_busmaster_regs.sv
`timescale 1ns/1ps
module tb_ide_busmaster_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  irq_req = '0, irq_dis = '0, sts_rd = '0;
  logic [31:0] rd_data, rd_data_p;
  logic        intrq, intrq_p;

  always #2 clk = ~clk;

  ide_busmaster_regs #(.EXTENDED(1'b1)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req),
    .irq_dis(irq_dis), .sts_rd(sts_rd), .intrq(intrq));

  ide_busmaster_regs #(.EXTENDED(1'b0)) dut_plain (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data_p), .irq_req(irq_req),
    .irq_dis(irq_dis), .sts_rd(sts_rd), .intrq(intrq_p));

  typedef struct {
    logic [31:0] exp;
    logic [31:0] exp_p;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_run = 0, n_fail = 0;
  logic  rd_seen = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && !rst) begin
      if (q.size() == 0) begin
        chk(1'b0, "scoreboard-empty", rd_data, 32'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(rd_data === it.exp, it.tag, rd_data, it.exp);
        chk(rd_data_p === it.exp_p, {it.tag, "/R11 plain"}, rd_data_p, it.exp_p);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp   = exp;
    it.exp_p = (!a[2] && a[0]) ? 32'h0000_00FF : exp;
    it.tag   = tag;
    q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] req, input logic [1:0] srd);
    @(negedge clk);
    irq_req = req; sts_rd = srd;
    @(negedge clk);
    irq_req = '0; sts_rd = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(intrq === 1'b0, "R1 intrq", {31'h0, intrq}, 32'h0);
    chk(intrq_p === 1'b0, "R1 intrq plain", {31'h0, intrq_p}, 32'h0);
    rd(4'h0, 32'h0, "R1 cmd0");
    rd(4'h1, 32'h0, "R1 mode");
    rd(4'hA, 32'h0, "R1 sts1");
    rd(4'hB, 32'h0, "R1 tim1");
    rd(4'h4, 32'h0, "R1 dtp0");

    wr(4'h0, 32'h0000_00FF);
    wr(4'h8, 32'h0000_0008);
    rd(4'h0, 32'h09, "R3 cmd0 mask");
    rd(4'h8, 32'h08, "R3 cmd1 direction");
    rd(4'h0, 32'h09, "R2 channel isolation");

    wr(4'h3, 32'h0000_00A5);
    wr(4'hB, 32'h0000_003C);
    rd(4'h3, 32'hA5, "R9 tim0");
    rd(4'hB, 32'h3C, "R9 tim1");

    wr(4'h4, 32'hDEAD_BEEF);
    wr(4'hF, 32'h1234_5677);
    rd(4'h6, 32'hDEAD_BEEC, "R10 dtp0 alias");
    rd(4'hC, 32'h1234_5674, "R10 dtp1");

    wr(4'h2, 32'h0000_00FF);
    rd(4'h2, 32'h60, "R4 status write ff");
    wr(4'h2, 32'h0000_0000);
    rd(4'h2, 32'h00, "R4 status write 00");

    pulse(2'b01, 2'b00);
    chk(intrq === 1'b1, "R6/R7 req ch0", {31'h0, intrq}, 32'h1);
    rd(4'h2, 32'h04, "R7 sts0 int");
    rd(4'h9, 32'h04, "R5/R7 pend0 via ch1 window");
    rd(4'hA, 32'h00, "R7 sts1 untouched");

    wr(4'h9, 32'h0000_0010);
    chk(intrq === 1'b0, "R6 blocked ch0", {31'h0, intrq}, 32'h0);
    rd(4'h1, 32'h14, "R5 block keeps pend");
    wr(4'h1, 32'h0000_00FF);
    rd(4'h1, 32'h34, "R5 write ff");
    wr(4'h1, 32'h0000_0000);
    chk(intrq === 1'b1, "R6 unblocked", {31'h0, intrq}, 32'h1);
    rd(4'h1, 32'h04, "R5 write 00 keeps pend");

    pulse(2'b00, 2'b01);
    chk(intrq === 1'b0, "R8 strobe clears", {31'h0, intrq}, 32'h0);
    rd(4'h1, 32'h00, "R8 pend0 cleared");
    rd(4'h2, 32'h04, "R8 status kept");
    wr(4'h2, 32'h0000_0004);
    rd(4'h2, 32'h00, "R4 w1c int");

    irq_dis = 2'b10;
    pulse(2'b10, 2'b00);
    chk(intrq === 1'b0, "R7 disabled", {31'h0, intrq}, 32'h0);
    rd(4'hA, 32'h00, "R7 disabled sts1");
    rd(4'h9, 32'h00, "R7 disabled mode");
    irq_dis = 2'b00;

    pulse(2'b10, 2'b00);
    chk(intrq === 1'b1, "R7 req ch1", {31'h0, intrq}, 32'h1);
    rd(4'h9, 32'h08, "R7 pend1");
    rd(4'hA, 32'h04, "R7 sts1 int");
    rd(4'h2, 32'h00, "R7 sts0 untouched");
    wr(4'h1, 32'h0000_0020);
    chk(intrq === 1'b0, "R6 blocked ch1", {31'h0, intrq}, 32'h0);
    wr(4'h1, 32'h0000_0010);
    chk(intrq === 1'b1, "R6 only ch0 blocked", {31'h0, intrq}, 32'h1);

    pulse(2'b01, 2'b01);
    rd(4'h1, 32'h1C, "R8 request beats strobe");
    chk(intrq === 1'b1, "R6 ch1 still drives", {31'h0, intrq}, 32'h1);

    @(negedge clk);
    wr_en = 1'b1; addr = 4'h2; wr_data = 32'h0000_0004; irq_req = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; irq_req = 2'b00;
    rd(4'h2, 32'h04, "R7 request beats w1c");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "scoreboard drained", q.size(), 32'h0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule